// File: doc/BRIEF.md
# Cache ECC Error Reporting Unit

This unit collects error-correction events raised by the tag directory and the data arrays of a shared cache and exposes them through a small 32-bit register bus. Events fall into four classes: directory corrected, data corrected, data uncorrectable and directory uncorrectable. For each class the unit latches the address of the most recent failure, counts how many failures occurred, and raises a dedicated interrupt line. Software services the interrupt by reading the address words and then the count register. Reading the count register is what drops the interrupt.

The unit also presents a read-only geometry word that describes the cache, a register that records the index of the highest enabled way, and an error-injection register. The injection register accepts only values inside two narrow windows. An accepted write emits a one-cycle request that carries a target select and the index of the bit to corrupt.

Top module: `ecc_err_report`

## Requirements
- R1: While reset is low, and right after it is released, every interrupt line and the injection request are 0. Every count reads 0, the injection register reads 0 and the way-enable register reads NUM_WAYS-1.
- R2: A read of offset 0x00 returns the geometry word. Bits 7:0 hold the bank count, bits 15:8 the way count, bits 23:16 log2 of sets per bank and bits 31:24 log2 of bytes per block.
- R3: Offset 0x08 is read/write in bits 7:0, which hold the index of the largest enabled way. Bits 31:8 read as 0.
- R4: An event on class c latches its address. Class base offsets are 0x100 for directory corrected, 0x140 for data corrected, 0x160 for data uncorrectable and 0x120 for directory uncorrectable. The address bits 31:0 read at base+0 and bits 63:32 at base+4. A later event replaces the stored address.
- R5: Each event on a class adds one to that class's count, read at base+8. The count stops at 2^CNT_W-1.
- R6: An event on a class sets interrupt line irq_o[c] in the next cycle. Line index c is 0 for directory corrected, 1 for data corrected, 2 for data uncorrectable and 3 for directory uncorrectable. The line stays set until it is cleared.
- R7: A bus read of a class's count register clears that class's interrupt in the next cycle. Reads of the address words do not change any interrupt.
- R8: If an event on a class arrives in the same cycle as a read of that class's count register, the interrupt stays set. The read returns the count as it was before the event.
- R9: A write to offset 0x40 with a value below 0xFF, or from 0x10000 through 0x100FE, is accepted. In the next cycle inj_valid_o is high for exactly one cycle, with inj_target_o equal to bit 16 and inj_bit_o equal to bits 7:0. Offset 0x40 then reads back the value masked with 0x100FF.
- R10: A write to offset 0x40 outside both windows is ignored. No request is emitted and the read-back value is unchanged.
- R11: Read data appears on rdata_o in the cycle after the read request. Any offset not listed above reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | REG_AW | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| ev_valid_i | input | 4 | Per-class ECC event strobe |
| ev_addr_i | input | 4*ADDR_W | Per-class failing address, class c in lane c |
| irq_o | output | 4 | Per-class interrupt lines |
| inj_valid_o | output | 1 | One-cycle injection request |
| inj_target_o | output | 1 | Injection target select |
| inj_bit_o | output | 8 | Index of the bit to corrupt |

## Verification
Events are applied to one class at a time and then to several classes in the same cycle. This shows that each class reaches the right interrupt line and the right register triple, and that the classes stay apart. Repeated events on one class separate address overwrite from count saturation. A count read timed against an event in the same cycle separates the clear path from the set path. Injection writes probe both window edges and values just outside them, which shows the window decode is exact and that rejected writes leave the stored value untouched.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
  localparam int NUM_CLS = 4;

  // class index = interrupt line index
  localparam int CLS_DIR_FIX  = 0;
  localparam int CLS_DAT_FIX  = 1;
  localparam int CLS_DAT_FAIL = 2;
  localparam int CLS_DIR_FAIL = 3;

  localparam int OFF_CFG = 'h00;
  localparam int OFF_WAY = 'h08;
  localparam int OFF_INJ = 'h40;

  function automatic int cls_base(input int c);
    case (c)
      CLS_DIR_FIX:  return 'h100;
      CLS_DAT_FIX:  return 'h140;
      CLS_DAT_FAIL: return 'h160;
      default:      return 'h120;
    endcase
  endfunction

  function automatic logic inj_in_window(input logic [31:0] v);
    return (v < 32'h0000_00FF) || (v >= 32'h0001_0000 && v <= 32'h0001_00FE);
  endfunction
endpackage

// File: rtl/ecc_err_class.sv
module ecc_err_class #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic              cnt_rd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (ev_i) begin
        addr_o <= ev_addr_i;
        if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      end
      // a new event outranks the clearing read
      if (ev_i)          irq_o <= 1'b1;
      else if (cnt_rd_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject import ecc_err_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        inj_valid_o,
  output logic        inj_target_o,
  output logic [7:0]  inj_bit_o,
  output logic [31:0] rdback_o
);
  logic accept;
  logic [31:0] inj_q;

  assign accept = wr_i && inj_in_window(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inj_q       <= '0;
      inj_valid_o <= 1'b0;
    end else begin
      inj_valid_o <= accept;
      if (accept) inj_q <= wdata_i & 32'h0001_00FF;
    end
  end

  assign inj_target_o = inj_q[16];
  assign inj_bit_o    = inj_q[7:0];
  assign rdback_o     = inj_q;
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report import ecc_err_pkg::*; #(
  parameter int REG_AW    = 12,
  parameter int ADDR_W    = 64,
  parameter int CNT_W     = 32,
  parameter int NUM_BANKS = 4,
  parameter int NUM_WAYS  = 16,
  parameter int LOG2_SETS = 10,
  parameter int LOG2_BLK  = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [REG_AW-1:0]         addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  input  logic [NUM_CLS-1:0]        ev_valid_i,
  input  logic [NUM_CLS*ADDR_W-1:0] ev_addr_i,
  output logic [NUM_CLS-1:0]        irq_o,
  output logic                      inj_valid_o,
  output logic                      inj_target_o,
  output logic [7:0]                inj_bit_o
);
  localparam logic [31:0] CFG_WORD = {8'(LOG2_BLK), 8'(LOG2_SETS), 8'(NUM_WAYS), 8'(NUM_BANKS)};
  localparam logic [7:0]  WAY_RST  = 8'(NUM_WAYS - 1);

  logic rd_en, wr_en;
  assign rd_en = req_i && !we_i;
  assign wr_en = req_i && we_i;

  logic [NUM_CLS-1:0] cnt_rd;
  logic [ADDR_W-1:0]  cls_addr [NUM_CLS];
  logic [CNT_W-1:0]   cls_cnt  [NUM_CLS];

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    assign cnt_rd[c] = rd_en && (addr_i == REG_AW'(cls_base(c) + 8));
    ecc_err_class #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cls (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev_valid_i[c]),
      .ev_addr_i (ev_addr_i[c*ADDR_W +: ADDR_W]),
      .cnt_rd_i  (cnt_rd[c]),
      .addr_o    (cls_addr[c]),
      .cnt_o     (cls_cnt[c]),
      .irq_o     (irq_o[c])
    );
  end

  logic [31:0] inj_rdback;
  ecc_err_inject u_inj (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_en && addr_i == REG_AW'(OFF_INJ)),
    .wdata_i      (wdata_i),
    .inj_valid_o  (inj_valid_o),
    .inj_target_o (inj_target_o),
    .inj_bit_o    (inj_bit_o),
    .rdback_o     (inj_rdback)
  );

  logic [7:0] way_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   way_q <= WAY_RST;
    else if (wr_en && addr_i == REG_AW'(OFF_WAY))  way_q <= wdata_i[7:0];
  end

  logic [31:0] rd_val;
  always_comb begin
    logic [63:0] ext;
    rd_val = '0;
    if (addr_i == REG_AW'(OFF_CFG)) rd_val = CFG_WORD;
    if (addr_i == REG_AW'(OFF_WAY)) rd_val = {24'b0, way_q};
    if (addr_i == REG_AW'(OFF_INJ)) rd_val = inj_rdback;
    for (int c = 0; c < NUM_CLS; c++) begin
      ext = 64'(cls_addr[c]);
      if (addr_i == REG_AW'(cls_base(c)))     rd_val = ext[31:0];
      if (addr_i == REG_AW'(cls_base(c) + 4)) rd_val = ext[63:32];
      if (addr_i == REG_AW'(cls_base(c) + 8)) rd_val = 32'(cls_cnt[c]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_en ? rd_val : '0;
  end
endmodule

// File: rtl/ecc_err_report_chk.sv
module ecc_err_report_chk import ecc_err_pkg::*; #(
  parameter int REG_AW = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [REG_AW-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic [NUM_CLS-1:0] ev_valid_i,
  input logic [NUM_CLS-1:0] irq_o,
  input logic               inj_valid_o
);
  logic inj_wr, rd_en, mapped;
  assign inj_wr = req_i && we_i && addr_i == REG_AW'(OFF_INJ);
  assign rd_en  = req_i && !we_i;

  always_comb begin
    mapped = addr_i == REG_AW'(OFF_CFG) || addr_i == REG_AW'(OFF_WAY) || addr_i == REG_AW'(OFF_INJ);
    for (int c = 0; c < NUM_CLS; c++)
      for (int k = 0; k < 3; k++)
        if (addr_i == REG_AW'(cls_base(c) + 4*k)) mapped = 1'b1;
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_c
    logic crd;
    assign crd = rd_en && addr_i == REG_AW'(cls_base(c) + 8);

    p_irq_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_valid_i[c] |=> irq_o[c]);
    p_irq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crd && !ev_valid_i[c]) |=> !irq_o[c]);
    p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!crd && !ev_valid_i[c]) |=> $stable(irq_o[c]));
    p_ev_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crd && ev_valid_i[c]) |=> irq_o[c]);
  end

  p_inj_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_o |-> $past(inj_wr && inj_in_window(wdata_i)));
  p_inj_rej_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_wr && !inj_in_window(wdata_i)) |=> !inj_valid_o);
  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !mapped) |=> rdata_o == 32'h0);
endmodule

bind ecc_err_report ecc_err_report_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .ev_valid_i  (ev_valid_i),
  .irq_o       (irq_o),
  .inj_valid_o (inj_valid_o)
);

// File: tb/ecc_err_report_test.sv
module ecc_err_report_test;
  localparam int AW = 12;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0] ev_valid_i = '0;
  logic [255:0] ev_addr_i = '0;
  logic [3:0] irq_o;
  logic inj_valid_o, inj_target_o;
  logic [7:0] inj_bit_o;

  always #5 clk_i = ~clk_i;

  ecc_err_report #(.REG_AW(AW), .CNT_W(CW)) uut (.*);

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  int base[4] = '{'h100, 'h140, 'h160, 'h120};
  logic [63:0] m_addr[4];
  int m_cnt[4];
  bit m_irq[4];
  bit [7:0] m_way;
  bit [31:0] m_inj;
  bit m_inj_v, m_rv;
  bit [31:0] m_rd;

  function automatic bit win(bit [31:0] v);
    return (v < 'hFF) || (v >= 'h10000 && v < 'h100FF);
  endfunction

  function automatic bit [31:0] mread(int a);
    if (a == 0) return {8'd6, 8'd10, 8'd16, 8'd4};
    if (a == 8) return {24'b0, m_way};
    if (a == 'h40) return m_inj;
    for (int c = 0; c < 4; c++) begin
      if (a == base[c]) return m_addr[c][31:0];
      if (a == base[c] + 4) return m_addr[c][63:32];
      if (a == base[c] + 8) return m_cnt[c];
    end
    return 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 4; c++) begin m_addr[c] = 0; m_cnt[c] = 0; m_irq[c] = 0; end
      m_way = 8'd15; m_inj = 0; m_inj_v = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = req_i && !we_i;
      if (m_rv) m_rd = mread(int'(addr_i));
      for (int c = 0; c < 4; c++) begin
        if (ev_valid_i[c]) begin
          m_addr[c] = ev_addr_i[c*64 +: 64];
          if (m_cnt[c] < CMAX) m_cnt[c]++;
          m_irq[c] = 1;
        end else if (m_rv && int'(addr_i) == base[c] + 8) m_irq[c] = 0;
      end
      if (req_i && we_i && addr_i == 8) m_way = wdata_i[7:0];
      m_inj_v = req_i && we_i && addr_i == 'h40 && win(wdata_i);
      if (m_inj_v) m_inj = wdata_i & 'h100FF;
    end
  end

  always @(negedge clk_i) if (rst_ni) begin
    cyc++;
    chk("R6/R7/R8 irq", irq_o, {m_irq[3], m_irq[2], m_irq[1], m_irq[0]});
    chk("R9/R10 inj_valid", inj_valid_o, m_inj_v);
    if (m_inj_v) chk("R9 inj fields", {inj_target_o, inj_bit_o}, {m_inj[16], m_inj[7:0]});
    if (m_rv) chk("R11 rdata", rdata_o, m_rd);
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic rd(input int a);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = AW'(a);
    @(negedge clk_i); req_i = 0;
  endtask
  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    rd(a); chk(tag, rdata_o, exp);
  endtask
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask
  task automatic ev(input logic [3:0] m, input logic [63:0] a);
    @(negedge clk_i); ev_valid_i = m;
    for (int c = 0; c < 4; c++) ev_addr_i[c*64 +: 64] = a + 64'(c);
    @(negedge clk_i); ev_valid_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq in reset", irq_o, 4'b0);
    chk("R1 inj in reset", inj_valid_o, 1'b0);
    rst_ni = 1;
    rd_chk('h00, 32'h060A_1004, "R2 config");
    rd_chk('h08, 32'h0F, "R1 way reset");
    rd_chk('h108, 0, "R1 count reset");
    rd_chk('h40, 0, "R1 inj reset");
    wr('h08, 32'hFFFF_FF05);
    rd_chk('h08, 32'h05, "R3 way");

    ev(4'b0001, 64'h1234_5678_9ABC_DEF0);
    chk("R6 class0 line", irq_o, 4'b0001);
    rd_chk('h100, 32'h9ABC_DEF0, "R4 low");
    rd_chk('h104, 32'h1234_5678, "R4 high");
    chk("R7 addr read keeps irq", irq_o, 4'b0001);
    rd_chk('h108, 1, "R5 count");
    chk("R7 count read clears", irq_o, 4'b0000);

    ev(4'b0010, 64'hA000_0000_0000_0100); chk("R6 class1 line", irq_o, 4'b0010);
    ev(4'b0100, 64'hB000_0000_0000_0200); chk("R6 class2 line", irq_o, 4'b0110);
    ev(4'b1000, 64'hC000_0000_0000_0300); chk("R6 class3 line", irq_o, 4'b1110);
    rd_chk('h164, 32'hB000_0000, "R4 class2 high");
    rd_chk('h120, 32'h0000_0303, "R4 class3 low");
    rd('h148); chk("R7 only class1 cleared", irq_o, 4'b1100);
    ev(4'b0100, 64'h0000_0001_0000_0777);
    rd_chk('h160, 32'h0000_0779, "R4 overwrite");
    rd_chk('h168, 2, "R5 class2 count");

    // same-cycle event and count read
    ev(4'b0100, 64'h55);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = AW'('h168); ev_valid_i = 4'b0100;
    @(negedge clk_i); req_i = 0; ev_valid_i = 0;
    chk("R8 read returns old count", rdata_o, 3);
    chk("R8 irq kept", irq_o[2], 1'b1);
    rd_chk('h168, 4, "R8 count after");

    for (int k = 0; k < 20; k++) ev(4'b0010, 64'(k));
    rd_chk('h148, CMAX, "R5 saturate");
    ev(4'b1111, 64'hDEAD_0000);
    chk("R6 all lines", irq_o, 4'b1111);
    rd_chk('h128, 2, "R5 class3 count");

    wr('h40, 32'h07);
    rd_chk('h40, 32'h07, "R9 readback");
    wr('h40, 32'h0001_0042);
    rd_chk('h40, 32'h0001_0042, "R9 target1");
    wr('h40, 32'hFE);
    wr('h40, 32'h0001_00FE);
    wr('h40, 32'h0001_0000);
    rd_chk('h40, 32'h0001_0000, "R9 window edge");
    wr('h40, 32'hFF);
    wr('h40, 32'h0001_00FF);
    wr('h40, 32'h0000_FFFF);
    wr('h40, 32'h0003_0001);
    rd_chk('h40, 32'h0001_0000, "R10 rejected keeps value");

    rd_chk('h04, 0, "R11 unmapped 0x04");
    rd_chk('h10C, 0, "R11 unmapped 0x10C");
    rd_chk('h200, 0, "R11 unmapped 0x200");
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule